// File: doc/BRIEF.md
# Multi-channel DMA transfer sequencer

This block is the data-moving engine of a four-channel DMA controller. A neighbouring register block holds each channel's control word, its working source address, destination address and remaining unit count, a programmed destination address, and a per-channel active bit that trigger logic sets. When the sequencer is idle and any channel is active, it takes the lowest-numbered active channel. It then copies that channel's units one at a time over a request/acknowledge memory bus. Each unit is a read from the source address followed by a write of the same data to the destination address.

The sequencer never writes the register block directly while a burst is in progress. It clears the channel's active bit when service begins. When service ends it issues one write-back pulse that carries the new working addresses and count, and it may ask for the enable bit to be cleared, for the active bit to be set again or cleared, and for an interrupt line to be pulsed. One mode, mode 7, feeds a FIFO in chunks. In that mode a burst is bounded and the channel re-arms itself from a FIFO half-empty flag until its count is used up.

Top module: `dma_seq`

## Requirements
- R1: When idle, the sequencer starts the lowest-numbered channel whose active bit is high. In that start cycle it pulses that channel's bit on `act_clr_o`, with no bus request yet.
- R2: Control bit 26 selects the unit size: 1 gives 32-bit units (`bus_wide_o` high, address step 4), 0 gives 16-bit units (only the low 16 data bits are written, address step 2).
- R3: Each unit is a read at the source address followed by a write of the data just read to the destination address. A request holds its address, direction and data until it is acknowledged.
- R4: The source control field, control bits 24:23, steps the source address after each unit: 0 increments, 1 decrements, 2 and 3 leave it fixed.
- R5: The destination control field, control bits 22:21, steps the destination address: 0 and 3 increment, 1 decrements, 2 leaves it fixed.
- R6: In mode 7 (control bits 29:27 equal 7), one service moves at most CHUNK units (112) and writes back the remaining count. It pulses `act_set_o` when `fifo_half_i` is high. While units remain, the channel is neither disabled nor interrupted.
- R7: A completed transfer with the repeat bit (bit 25) set and a mode other than 0 writes back the count from control bits 20:0 and keeps the channel enabled. The destination is reloaded from `dst_prog_i` only when the destination control field is 3.
- R8: A completed transfer without repeat, or in mode 0, asserts `wb_disable_o` (the enable bit, bit 31, is to be cleared), pulses `act_clr_o` for the channel and writes back a count of 0.
- R9: When control bit 30 is set, every completed transfer, repeating or not, pulses the channel's `irq_o` bit for one cycle in the write-back cycle.
- R10: A count of zero makes no bus access, and the channel completes at once.
- R11: A service is never pre-empted. A channel that becomes active during a burst, even a lower-numbered one, waits until the burst's write-back.
- R12: Every service ends with exactly one `wb_valid_o` cycle. In that cycle `wb_chan_o` and `wb_src_o`/`wb_dst_o`/`wb_cnt_o` carry the new working values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_i | input | NCH | Per-channel active bits |
| ctrl_i | input | NCH x 32 | Per-channel control words |
| src_i | input | NCH x AW | Working source addresses |
| dst_i | input | NCH x AW | Working destination addresses |
| dst_prog_i | input | NCH x AW | Programmed destination addresses |
| cnt_i | input | NCH x CW | Working unit counts |
| fifo_half_i | input | 1 | FIFO half-empty flag |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write (1) or read (0) |
| bus_wide_o | output | 1 | 32-bit unit (1) or 16-bit unit (0) |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Bus acknowledge, one cycle |
| act_clr_o | output | NCH | Clear active bit pulses |
| act_set_o | output | NCH | Set active bit pulses |
| irq_o | output | NCH | End-of-transfer interrupt pulses |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_chan_o | output | CHW | Channel being written back |
| wb_src_o | output | AW | New working source address |
| wb_dst_o | output | AW | New working destination address |
| wb_cnt_o | output | CW | New working count |
| wb_disable_o | output | 1 | Clear the channel's enable bit |

## Verification
The bench builds the block with its defaults: four channels, a 28-bit address, a 21-bit count and a chunk of 112. With these values, a mode-7 count of 250 spans two full chunks and a partial one, and a count of 150 leaves a remainder that must survive a pause while the FIFO flag is low. All four channels are used at once, so the fixed priority order can be seen, and a lower-numbered channel is raised in the middle of a burst. The bus model adds random acknowledge delays of zero to two cycles, so request holding and address stepping are exercised at several speeds.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } seq_state_e;

  // control word field positions
  localparam int unsigned BIT_ENABLE = 31;
  localparam int unsigned BIT_IRQ    = 30;
  localparam int unsigned MODE_LSB   = 27;
  localparam int unsigned BIT_WIDE   = 26;
  localparam int unsigned BIT_RPT    = 25;
  localparam int unsigned SCTL_LSB   = 23;
  localparam int unsigned DCTL_LSB   = 21;

  localparam logic [2:0] MODE_NOW  = 3'd0;
  localparam logic [2:0] MODE_FIFO = 3'd7;

  localparam logic [1:0] CTL_INC = 2'd0;
  localparam logic [1:0] CTL_DEC = 2'd1;
  localparam logic [1:0] CTL_RLD = 2'd3;

endpackage

// File: rtl/dma_seq_pick.sv
module dma_seq_pick #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CHW = 2
) (
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [CHW-1:0] idx_o,
  output logic [NCH-1:0] grant_o
);

  // fixed priority: lowest index wins
  for (genvar g = 0; g < NCH; g++) begin : g_grant
    if (g == 0) begin : g_first
      assign grant_o[g] = req_i[g];
    end else begin : g_rest
      assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant_o[i]) idx_o = idx_o | CHW'(i);
    end
  end

endmodule

// File: rtl/dma_seq_step.sv
module dma_seq_step #(
  parameter int unsigned AW     = 28,
  parameter bit          IS_DST = 1'b0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    ctl_i,
  input  logic          wide_i,
  output logic [AW-1:0] addr_o
);
  import dma_seq_pkg::*;

  logic [AW-1:0] stride;
  logic          up;
  logic          down;

  always_comb begin
    stride = wide_i ? AW'(4) : AW'(2);
    up     = (ctl_i == CTL_INC) || (IS_DST && (ctl_i == CTL_RLD));
    down   = (ctl_i == CTL_DEC);
    if (up)        addr_o = addr_i + stride;
    else if (down) addr_o = addr_i - stride;
    else           addr_o = addr_i;
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned AW    = 28,
  parameter int unsigned CW    = 21,
  parameter int unsigned CHUNK = 112,
  localparam int unsigned CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           active_i,
  input  logic [NCH-1:0][31:0]     ctrl_i,
  input  logic [NCH-1:0][AW-1:0]   src_i,
  input  logic [NCH-1:0][AW-1:0]   dst_i,
  input  logic [NCH-1:0][AW-1:0]   dst_prog_i,
  input  logic [NCH-1:0][CW-1:0]   cnt_i,
  input  logic                     fifo_half_i,
  output logic                     bus_req_o,
  output logic                     bus_we_o,
  output logic                     bus_wide_o,
  output logic [AW-1:0]            bus_addr_o,
  output logic [31:0]              bus_wdata_o,
  input  logic [31:0]              bus_rdata_i,
  input  logic                     bus_ack_i,
  output logic [NCH-1:0]           act_clr_o,
  output logic [NCH-1:0]           act_set_o,
  output logic [NCH-1:0]           irq_o,
  output logic                     wb_valid_o,
  output logic [CHW-1:0]           wb_chan_o,
  output logic [AW-1:0]            wb_src_o,
  output logic [AW-1:0]            wb_dst_o,
  output logic [CW-1:0]            wb_cnt_o,
  output logic                     wb_disable_o
);

  localparam int unsigned BW = $clog2(CHUNK + 1);

  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q;
  logic [31:0]    ctrl_q;
  logic [AW-1:0]  src_q, dst_q;
  logic [CW-1:0]  rem_q;
  logic [BW-1:0]  burst_q;
  logic [31:0]    data_q;

  logic           pick_any;
  logic [CHW-1:0] pick_idx;
  logic [NCH-1:0] pick_grant;
  logic [AW-1:0]  src_nx, dst_nx;

  logic           ld_start, ld_data, ld_step;
  logic [2:0]     mode;
  logic           wide, is_fifo, chunk_full;
  logic           finished, rpt, reload, stop, in_done;
  logic [NCH-1:0] ch_onehot;
  logic           unused_enable;

  dma_seq_pick #(.NCH(NCH), .CHW(CHW)) i_pick (
    .req_i   (active_i),
    .any_o   (pick_any),
    .idx_o   (pick_idx),
    .grant_o (pick_grant)
  );

  dma_seq_step #(.AW(AW), .IS_DST(1'b0)) i_src_step (
    .addr_i (src_q),
    .ctl_i  (ctrl_q[SCTL_LSB +: 2]),
    .wide_i (wide),
    .addr_o (src_nx)
  );

  dma_seq_step #(.AW(AW), .IS_DST(1'b1)) i_dst_step (
    .addr_i (dst_q),
    .ctl_i  (ctrl_q[DCTL_LSB +: 2]),
    .wide_i (wide),
    .addr_o (dst_nx)
  );

  // decode of the latched control word
  always_comb begin
    mode          = ctrl_q[MODE_LSB +: 3];
    wide          = ctrl_q[BIT_WIDE];
    is_fifo       = (mode == MODE_FIFO);
    chunk_full    = is_fifo && (burst_q == BW'(CHUNK));
    finished      = !(is_fifo && (rem_q != '0));
    rpt           = ctrl_q[BIT_RPT] && (mode != MODE_NOW);
    reload        = finished && rpt;
    stop          = finished && !rpt;
    in_done       = (state_q == ST_DONE);
    ch_onehot     = NCH'(1) << ch_q;
    unused_enable = ctrl_q[BIT_ENABLE];
  end

  // next state and clock enables
  always_comb begin
    state_d  = state_q;
    ld_start = 1'b0;
    ld_data  = 1'b0;
    ld_step  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pick_any) begin
          ld_start = 1'b1;
          state_d  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if ((rem_q == '0) || chunk_full) state_d = ST_DONE;
        else                             state_d = ST_READ;
      end
      ST_READ: begin
        if (bus_ack_i) begin
          ld_data = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (bus_ack_i) begin
          ld_step = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q    <= '0;
      ctrl_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      burst_q <= '0;
    end else if (ld_start) begin
      ch_q    <= pick_idx;
      ctrl_q  <= ctrl_i[pick_idx];
      src_q   <= src_i[pick_idx];
      dst_q   <= dst_i[pick_idx];
      rem_q   <= cnt_i[pick_idx];
      burst_q <= '0;
    end else if (ld_step) begin
      src_q   <= src_nx;
      dst_q   <= dst_nx;
      rem_q   <= rem_q - CW'(1);
      burst_q <= burst_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (ld_data) data_q <= bus_rdata_i;
  end

  // bus side
  always_comb begin
    bus_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
    bus_we_o    = (state_q == ST_WRITE);
    bus_wide_o  = wide;
    bus_addr_o  = bus_we_o ? dst_q : src_q;
    bus_wdata_o = wide ? data_q : {16'h0000, data_q[15:0]};
  end

  // register update side
  always_comb begin
    if (ld_start)           act_clr_o = pick_grant;
    else if (in_done && stop) act_clr_o = ch_onehot;
    else                    act_clr_o = '0;
    act_set_o    = (in_done && is_fifo && fifo_half_i && !stop) ? ch_onehot : '0;
    irq_o        = (in_done && finished && ctrl_q[BIT_IRQ]) ? ch_onehot : '0;
    wb_valid_o   = in_done;
    wb_chan_o    = ch_q;
    wb_src_o     = src_q;
    wb_dst_o     = (reload && (ctrl_q[DCTL_LSB +: 2] == CTL_RLD)) ? dst_prog_i[ch_q] : dst_q;
    wb_cnt_o     = reload ? ctrl_q[CW-1:0] : rem_q;
    wb_disable_o = in_done && stop;
  end

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned AW    = 28,
  parameter int unsigned CHUNK = 112,
  localparam int unsigned CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0][31:0] ctrl_i,
  input logic [NCH-1:0]       act_clr_o,
  input logic [NCH-1:0]       act_set_o,
  input logic [NCH-1:0]       irq_o,
  input logic                 wb_valid_o,
  input logic                 wb_disable_o,
  input logic                 bus_req_o,
  input logic                 bus_ack_i,
  input logic                 bus_we_o,
  input logic [AW-1:0]        bus_addr_o,
  input logic [31:0]          bus_wdata_o
);

  logic           busy_q;
  logic [CHW-1:0] cur_q;
  logic [15:0]    units_q;
  logic           start;
  logic [CHW-1:0] start_idx;
  logic           cur_fifo;
  logic           unused_ctrl;

  always_comb begin
    start     = (act_clr_o != '0) && !wb_valid_o;
    start_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (act_clr_o[i]) start_idx = start_idx | CHW'(i);
    end
    cur_fifo    = (ctrl_i[cur_q][29:27] == 3'd7);
    unused_ctrl = ^ctrl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      units_q <= '0;
    end else begin
      if (start) begin
        busy_q  <= 1'b1;
        cur_q   <= start_idx;
        units_q <= '0;
      end else begin
        if (wb_valid_o) busy_q <= 1'b0;
        if (bus_req_o && bus_we_o && bus_ack_i && (units_q != 16'hFFFF))
          units_q <= units_q + 16'd1;
      end
    end
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_clr_o)); // R1
  AST_START_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !bus_req_o); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)); // R3
  AST_FIFO_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cur_fifo |-> units_q <= 16'(CHUNK)); // R6
  AST_REARM_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    act_set_o != '0 |-> wb_valid_o && cur_fifo && !wb_disable_o); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_disable_o |-> act_clr_o != '0); // R8
  AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o != '0 |-> wb_valid_o && $onehot(irq_o)); // R9
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !wb_valid_o |-> act_clr_o == '0); // R11
  AST_WB_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> busy_q && !bus_req_o); // R12

endmodule

bind dma_seq dma_seq_chk #(.NCH(NCH), .AW(AW), .CHUNK(CHUNK)) i_chk (.*);

// File: tb/test_dma_seq.sv
`timescale 1ns/1ps
module test_dma_seq;
  localparam int NCH = 4, AW = 28, CW = 21, CHUNK = 112, MEMB = 2048;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic [NCH-1:0][31:0]   r_ctrl;
  logic [NCH-1:0][AW-1:0] r_src, r_dst, r_dprog;
  logic [NCH-1:0][CW-1:0] r_cnt;
  logic [NCH-1:0]         r_act, trig;
  logic                   fifo_half;

  logic bus_req, bus_we, bus_wide, ack_q;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, rdata_q;
  logic [NCH-1:0] act_clr, act_set, irq;
  logic wb_valid, wb_disable;
  logic [1:0] wb_chan;
  logic [AW-1:0] wb_src, wb_dst;
  logic [CW-1:0] wb_cnt;

  dma_seq #(.NCH(NCH), .AW(AW), .CW(CW), .CHUNK(CHUNK)) i_dma_seq (
    .clk(clk), .rst_n(rst_n), .active_i(r_act), .ctrl_i(r_ctrl),
    .src_i(r_src), .dst_i(r_dst), .dst_prog_i(r_dprog), .cnt_i(r_cnt),
    .fifo_half_i(fifo_half), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_wide_o(bus_wide), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(rdata_q), .bus_ack_i(ack_q), .act_clr_o(act_clr),
    .act_set_o(act_set), .irq_o(irq), .wb_valid_o(wb_valid),
    .wb_chan_o(wb_chan), .wb_src_o(wb_src), .wb_dst_o(wb_dst),
    .wb_cnt_o(wb_cnt), .wb_disable_o(wb_disable)
  );

  logic [7:0] mem [MEMB];
  logic [7:0] refm [MEMB];
  int dly;

  // memory responder with random acknowledge delay
  always @(posedge clk) begin
    int a;
    if (!rst_n) begin
      ack_q <= 1'b0;
      dly   <= 0;
    end else if (ack_q) begin
      ack_q <= 1'b0;
    end else if (bus_req) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        ack_q <= 1'b1;
        dly   <= int'($urandom % 3);
        a = int'(bus_addr % MEMB);
        if (bus_we) begin
          mem[a] <= bus_wdata[7:0];
          mem[(a+1)%MEMB] <= bus_wdata[15:8];
          if (bus_wide) begin
            mem[(a+2)%MEMB] <= bus_wdata[23:16];
            mem[(a+3)%MEMB] <= bus_wdata[31:24];
          end
        end else begin
          rdata_q <= {mem[(a+3)%MEMB], mem[(a+2)%MEMB], mem[(a+1)%MEMB], mem[a]};
        end
      end
    end
  end

  // neighbouring register block model
  always @(posedge clk) begin
    if (!rst_n) r_act <= '0;
    else begin
      r_act <= (r_act & ~act_clr) | act_set | trig;
      if (wb_valid) begin
        r_src[wb_chan] <= wb_src;
        r_dst[wb_chan] <= wb_dst;
        r_cnt[wb_chan] <= wb_cnt;
        if (wb_disable) r_ctrl[wb_chan][31] <= 1'b0;
      end
    end
  end

  // monitor, sampled away from the active edge
  int n_start = 0, n_wb = 0, n_wr = 0, n_rd = 0, bad_start = 0;
  int order [64];
  int irq_n [NCH];
  logic [CW-1:0] h_cnt [64];
  logic [AW-1:0] h_src [64], h_dst [64];
  logic h_set [64], h_dis [64];

  always @(negedge clk) begin
    if (rst_n) begin
      if (act_clr != '0 && !wb_valid) begin
        for (int i = 0; i < NCH; i++) if (act_clr[i]) order[n_start % 64] = i;
        if (bus_req) bad_start++;
        n_start++;
      end
      if (wb_valid) begin
        h_cnt[n_wb % 64] = wb_cnt;
        h_src[n_wb % 64] = wb_src;
        h_dst[n_wb % 64] = wb_dst;
        h_set[n_wb % 64] = (act_set != '0);
        h_dis[n_wb % 64] = wb_disable;
        n_wb++;
      end
      for (int i = 0; i < NCH; i++) if (irq[i]) irq_n[i]++;
      if (bus_req && ack_q) begin
        if (bus_we) n_wr++;
        else        n_rd++;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mkctrl(input int mode, input bit wide, input bit rpt,
                                         input bit ien, input int sctl, input int dctl, input int cnt);
    logic [31:0] c;
    c = '0;
    c[31] = 1'b1;
    c[30] = ien;
    c[29:27] = 3'(mode);
    c[26] = wide;
    c[25] = rpt;
    c[24:23] = 2'(sctl);
    c[22:21] = 2'(dctl);
    c[20:0] = 21'(cnt);
    return c;
  endfunction

  // reference move on the reference memory, from the requirements
  task automatic ref_move(input logic [31:0] c, input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                          input int units, output logic [AW-1:0] s, output logic [AW-1:0] d);
    int st, nb;
    st = c[26] ? 4 : 2;
    s = s0;
    d = d0;
    for (int j = 0; j < units; j++) begin
      for (int b = 0; b < st; b++) refm[(int'(d % MEMB) + b) % MEMB] = refm[(int'(s % MEMB) + b) % MEMB];
      if (c[24:23] == 2'd0) s = s + AW'(st);
      else if (c[24:23] == 2'd1) s = s - AW'(st);
      if (c[22:21] == 2'd0 || c[22:21] == 2'd3) d = d + AW'(st);
      else if (c[22:21] == 2'd1) d = d - AW'(st);
    end
    nb = 0;
  endtask

  task automatic mem_check(input string req);
    int mism;
    mism = 0;
    for (int i = 0; i < MEMB; i++) if (mem[i] !== refm[i]) mism++;
    check(req, "memory mismatches", mism, 0);
  endtask

  task automatic prog(input int ch, input logic [31:0] c, input logic [AW-1:0] s,
                      input logic [AW-1:0] d, input logic [AW-1:0] dp);
    @(negedge clk);
    r_ctrl[ch]  = c;
    r_src[ch]   = s;
    r_dst[ch]   = d;
    r_dprog[ch] = dp;
    r_cnt[ch]   = c[CW-1:0];
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk);
    trig = m;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic wait_wb(input int n);
    while (n_wb < n) @(negedge clk);
  endtask

  // one complete non-chunked service, compared with the reference
  task automatic run_one(input string req, input int ch, input logic [31:0] c,
                         input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [AW-1:0] dp);
    logic [AW-1:0] es, ed;
    bit rp;
    int n0, i0, w0, r0;
    prog(ch, c, s, d, dp);
    ref_move(c, s, d, int'(c[CW-1:0]), es, ed);
    rp = c[25] && (c[29:27] != 3'd0);
    if (rp && c[22:21] == 2'd3) ed = dp;
    n0 = n_wb; i0 = irq_n[ch]; w0 = n_wr; r0 = n_rd;
    pulse(4'(1 << ch));
    wait_wb(n0 + 1);
    repeat (2) @(negedge clk);
    check(req, "wb source", h_src[n0 % 64], es);
    check(req, "wb destination", h_dst[n0 % 64], ed);
    check(req, "wb count", h_cnt[n0 % 64], rp ? longint'(c[CW-1:0]) : 0);
    check(req, "wb disable", h_dis[n0 % 64], !rp);
    check(req, "enable bit kept", r_ctrl[ch][31], rp);
    check(req, "irq pulses", irq_n[ch] - i0, c[30]);
    check(req, "unit writes", n_wr - w0, c[CW-1:0]);
    check(req, "unit reads", n_rd - r0, c[CW-1:0]);
    mem_check(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    trig = '0;
    fifo_half = 1'b0;
    r_ctrl = '0; r_src = '0; r_dst = '0; r_dprog = '0; r_cnt = '0;
    for (int i = 0; i < NCH; i++) irq_n[i] = 0;
    for (int i = 0; i < MEMB; i++) begin
      mem[i] = 8'($urandom);
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "reset wb_valid", wb_valid, 0);
    check("R3", "reset bus_req", bus_req, 0);
    check("R9", "reset irq", irq, 0);
    check("R1", "reset act_clr", act_clr, 0);

    // R2 R4 R5: half words, both incrementing, interrupt on
    run_one("R2", 0, mkctrl(1, 0, 0, 1, 0, 0, 5), 28'h100, 28'h500, 28'h0);
    // R2 R4 R5: words, both decrementing
    run_one("R4", 2, mkctrl(3, 1, 0, 0, 1, 1, 3), 28'h200, 28'h600, 28'h0);
    // R4 R5: both fixed
    run_one("R5", 1, mkctrl(2, 0, 0, 1, 2, 2, 3), 28'h120, 28'h520, 28'h0);
    // R4 R5: source code 3 fixed, destination code 3 increments
    run_one("R5", 3, mkctrl(4, 1, 0, 0, 3, 3, 4), 28'h140, 28'h540, 28'h0);
    // R7: repeat in a non-zero mode reloads count and, for code 3, destination
    run_one("R7", 0, mkctrl(2, 0, 1, 1, 0, 3, 4), 28'h160, 28'h560, 28'h6A0);
    // R7: repeat with destination code 0 keeps the stepped destination
    run_one("R7", 1, mkctrl(5, 1, 1, 1, 0, 0, 2), 28'h180, 28'h580, 28'h7F0);
    // R8: repeat bit in mode 0 still ends the transfer
    run_one("R8", 2, mkctrl(0, 0, 1, 1, 0, 0, 3), 28'h1A0, 28'h5A0, 28'h0);
    // R10: zero count makes no bus access
    run_one("R10", 3, mkctrl(1, 1, 0, 1, 0, 0, 0), 28'h1C0, 28'h5C0, 28'h0);

    // R6: chunked fill with the FIFO flag high, three services
    begin
      logic [AW-1:0] es, ed;
      int n0, i0, w0;
      fifo_half = 1'b1;
      prog(1, mkctrl(7, 0, 0, 1, 0, 0, 250), 28'h100, 28'h400, 28'h0);
      ref_move(r_ctrl[1], 28'h100, 28'h400, 250, es, ed);
      n0 = n_wb; i0 = irq_n[1]; w0 = n_wr;
      pulse(4'b0010);
      wait_wb(n0 + 3);
      repeat (2) @(negedge clk);
      check("R6", "count after chunk 1", h_cnt[n0 % 64], 138);
      check("R6", "count after chunk 2", h_cnt[(n0+1) % 64], 26);
      check("R6", "count after chunk 3", h_cnt[(n0+2) % 64], 0);
      check("R6", "re-arm chunk 1", h_set[n0 % 64], 1);
      check("R6", "re-arm chunk 2", h_set[(n0+1) % 64], 1);
      check("R8", "no re-arm at end", h_set[(n0+2) % 64], 0);
      check("R6", "no disable mid-way", h_dis[(n0+1) % 64], 0);
      check("R8", "disable at end", h_dis[(n0+2) % 64], 1);
      check("R9", "one irq for chunked transfer", irq_n[1] - i0, 1);
      check("R6", "unit writes", n_wr - w0, 250);
      check("R6", "final source", h_src[(n0+2) % 64], es);
      check("R8", "channel inactive", r_act[1], 0);
      mem_check("R6");
    end

    // R6: FIFO flag low, the remainder waits for a new activation
    begin
      logic [AW-1:0] es, ed;
      int n0, i0, w0;
      fifo_half = 1'b0;
      prog(0, mkctrl(7, 1, 0, 1, 0, 0, 150), 28'h100, 28'h400, 28'h0);
      ref_move(r_ctrl[0], 28'h100, 28'h400, 112, es, ed);
      n0 = n_wb; i0 = irq_n[0]; w0 = n_wr;
      pulse(4'b0001);
      wait_wb(n0 + 1);
      repeat (20) @(negedge clk);
      check("R6", "single service", n_wb - n0, 1);
      check("R6", "remaining count", h_cnt[n0 % 64], 38);
      check("R6", "no re-arm", r_act[0], 0);
      check("R6", "no irq yet", irq_n[0] - i0, 0);
      check("R6", "enable kept", r_ctrl[0][31], 1);
      check("R6", "chunk writes", n_wr - w0, 112);
      mem_check("R6");
      ref_move(r_ctrl[0], es, ed, 38, es, ed);
      n0 = n_wb;
      pulse(4'b0001);
      wait_wb(n0 + 1);
      repeat (2) @(negedge clk);
      check("R6", "rest completes", h_cnt[n0 % 64], 0);
      check("R6", "rest destination", h_dst[n0 % 64], ed);
      check("R9", "irq at completion", irq_n[0] - i0, 1);
      mem_check("R6");
    end

    // R1 R11: priority order and no pre-emption
    begin
      logic [AW-1:0] es, ed;
      int n0, s0;
      prog(1, mkctrl(1, 0, 0, 0, 0, 0, 2), 28'h100, 28'h500, 28'h0);
      prog(2, mkctrl(1, 0, 0, 0, 0, 0, 2), 28'h140, 28'h540, 28'h0);
      prog(3, mkctrl(1, 0, 0, 0, 0, 0, 2), 28'h180, 28'h580, 28'h0);
      prog(0, mkctrl(1, 0, 0, 0, 0, 0, 2), 28'h1C0, 28'h5C0, 28'h0);
      for (int c = 0; c < NCH; c++) ref_move(r_ctrl[c], r_src[c], r_dst[c], 2, es, ed);
      n0 = n_wb; s0 = n_start;
      pulse(4'b1110);
      while (n_start < s0 + 2) @(negedge clk);
      pulse(4'b0001);
      wait_wb(n0 + 4);
      repeat (2) @(negedge clk);
      check("R1", "first serviced", order[s0 % 64], 1);
      check("R1", "second serviced", order[(s0+1) % 64], 2);
      check("R11", "raised mid-burst waits", order[(s0+2) % 64], 0);
      check("R11", "last serviced", order[(s0+3) % 64], 3);
      mem_check("R11");
    end

    // random services against the reference
    for (int it = 0; it < 16; it++) begin
      int ch;
      ch = int'($urandom % NCH);
      run_one("R3", ch,
              mkctrl(int'($urandom % 7), 1'($urandom), 1'($urandom), 1'($urandom),
                     int'($urandom % 4), int'($urandom % 4), 1 + int'($urandom % 8)),
              AW'(28'h100 + ($urandom % 128) * 4), AW'(28'h500 + ($urandom % 64) * 4),
              AW'($urandom % 4096));
    end

    check("R1", "starts with bus busy", bad_start, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R12: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule